// File: doc/BRIEF.md
# Switched Endpoint Crossbar with Per-Endpoint Arbitration

This block is the internal switch of a small real-time subsystem. Three initiators share it: two real-time cores (index 0 and 1) and a host port (index 2) carrying traffic from outside the subsystem. Four independent endpoints sit behind it: a data memory local to core 0 (endpoint 0), a data memory local to core 1 (endpoint 1), a shared memory (endpoint 2) and a peripheral (endpoint 3). Each initiator presents a request, a 2-bit endpoint index, a write flag, a burst length in bytes and 32-bit write data. The block answers with a grant that stays high for every beat of the burst. It steers each beat to the chosen endpoint and brings the endpoint's read data back.

Every endpoint has its own arbiter, so traffic to different endpoints never interacts. An arbiter decides only when its endpoint is idle or on the clock that ends the current burst. The winner is registered with a beat counter and keeps the endpoint locked until the count runs out. Cores beat the host. Between the two cores, the core whose local memory is the target wins on that memory. Everywhere else core 0 wins. An initiator must keep its request and fields steady until it sees its grant, and must drop the request in that first granted cycle.

Top module: `rt_xbar`

## Requirements
- R1: Requests from different initiators to different endpoints, raised in the same cycle, are all granted in the cycle after they are first sampled, with no delay.
- R2: A burst of x bytes holds the grant and the endpoint valid for ceil(x/4) consecutive cycles (30 bytes gives 8 cycles, 5 bytes gives 2); a length of 0 is treated as one beat.
- R3: When a core and the host request the same free endpoint in the same cycle, the core is granted first and the host follows on the clock the core's burst ends.
- R4: When both cores request the same free endpoint in the same cycle, core 1 wins on endpoint 1 and core 0 wins on endpoints 0, 2 and 3.
- R5: A running burst is never preempted: a core that requests during a host burst of B beats is granted on the edge that ends that burst, so its grant rises exactly B cycles after the host's grant rose.
- R6: When the host issues single 4-byte accesses, a core request raised during one of them is granted at the very next arbitration point, ahead of the host's following access.
- R7: A request that loses arbitration stays pending and is granted later without being re-issued; no request is dropped.
- R8: While a burst owns an endpoint, that endpoint's valid is high, its source field names the owner (0, 1 or 2), its write flag and write data come from the owner, and the owner's read data output carries that endpoint's read data.
- R9: During and right after reset, all grants and all endpoint valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ini_req | input | 3 | Request per initiator (core 0, core 1, host) |
| ini_ep | input | 6 | Endpoint index per initiator, 2 bits each |
| ini_wr | input | 3 | Write flag per initiator |
| ini_len | input | 24 | Burst length in bytes per initiator, 8 bits each |
| ini_wdata | input | 96 | Write data per initiator, 32 bits each |
| ini_gnt | output | 3 | Grant per initiator, high on every beat |
| ini_rdata | output | 96 | Read data returned per initiator |
| ep_vld | output | 4 | Beat valid per endpoint |
| ep_last | output | 4 | Final beat of the burst per endpoint |
| ep_wr | output | 4 | Write flag per endpoint |
| ep_src | output | 8 | Owning initiator per endpoint, 2 bits each |
| ep_wdata | output | 128 | Write data per endpoint |
| ep_rdata | input | 128 | Read data from each endpoint |

## Verification
A corrupted lock or beat counter shows at the ports as a grant that is one or more cycles too short or too long. It shows within the burst it hits, and a waiting initiator then starts on the wrong cycle. A wrong priority choice shows one cycle after the conflict as a grant on the wrong initiator. A wrong owner field shows the same cycle on the endpoint's source, write data and the returned read data. The bench therefore predicts the exact start cycle and duration of every grant and checks the routing on each grant's first beat.

// File: rtl/rt_xbar_pkg.sv
package rt_xbar_pkg;
  localparam int N_INI = 3;
  localparam int SRC_W = 2;
  localparam int CORE0 = 0;
  localparam int CORE1 = 1;
  localparam int HOST  = 2;
endpackage

// File: rtl/rt_xbar_ep_arb.sv
module rt_xbar_ep_arb
  import rt_xbar_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int FAV   = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_INI-1:0]       cand_i,
  input  logic [N_INI*LEN_W-1:0] len_i,
  input  logic [N_INI-1:0]       wr_i,
  output logic                   busy_o,
  output logic                   last_o,
  output logic [SRC_W-1:0]       owner_o,
  output logic                   wr_o
);
  localparam int OTHER = 1 - FAV;

  logic             busy_q, busy_d;
  logic [SRC_W-1:0] owner_q, owner_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             last, arb_ok, win_vld, upd;
  logic [SRC_W-1:0] win;
  logic [N_INI-1:0] cand_eff;
  logic [LEN_W-1:0] sel_len;
  logic             sel_wr;

  function automatic logic [LEN_W-1:0] beats_of(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] t;
    t = {1'b0, len} + (LEN_W+1)'(3);
    if (len == '0) return LEN_W'(1);
    return LEN_W'(t >> 2);
  endfunction

  always_comb begin
    last   = busy_q && (cnt_q == LEN_W'(1));
    arb_ok = !busy_q || last;
    cand_eff = cand_i;
    for (int i = 0; i < N_INI; i++) begin
      if (last && owner_q == SRC_W'(i)) cand_eff[i] = 1'b0;
    end
    win_vld = 1'b1;
    if (cand_eff[FAV])        win = SRC_W'(FAV);
    else if (cand_eff[OTHER]) win = SRC_W'(OTHER);
    else if (cand_eff[HOST])  win = SRC_W'(HOST);
    else begin
      win_vld = 1'b0;
      win     = owner_q;
    end
    sel_len = '0;
    sel_wr  = 1'b0;
    for (int i = 0; i < N_INI; i++) begin
      if (win == SRC_W'(i)) begin
        sel_len = len_i[i*LEN_W +: LEN_W];
        sel_wr  = wr_i[i];
      end
    end
  end

  // next-state
  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    if (arb_ok) begin
      if (win_vld) begin
        busy_d  = 1'b1;
        owner_d = win;
        cnt_d   = beats_of(sel_len);
        wr_d    = sel_wr;
      end else begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
    end else begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  assign upd = busy_q || (|cand_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else if (upd) begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  assign busy_o  = busy_q;
  assign last_o  = last;
  assign owner_o = owner_q;
  assign wr_o    = wr_q;

  // R5: a burst in progress keeps its owner until its final beat
  a_r5_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> busy_q && $stable(owner_q));
  // R2: the beat counter steps down by one per beat
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> cnt_q == $past(cnt_q) - LEN_W'(1));
  // R3: any core candidate at an arbitration point keeps the host out
  a_r3_core_first: assert property (@(posedge clk) disable iff (!rst_n)
    arb_ok && (cand_eff[CORE0] || cand_eff[CORE1]) |=> owner_q != SRC_W'(HOST));
  // R4: the favoured core of this endpoint wins
  a_r4_fav_wins: assert property (@(posedge clk) disable iff (!rst_n)
    arb_ok && cand_eff[FAV] |=> owner_q == SRC_W'(FAV));
  // R7: a pending candidate at an arbitration point is always served
  a_r7_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    arb_ok && (|cand_eff) |=> busy_q);
endmodule

// File: rtl/rt_xbar_route.sv
module rt_xbar_route
  import rt_xbar_pkg::*;
#(
  parameter int DW   = 32,
  parameter int N_EP = 4
) (
  input  logic [N_EP-1:0]       ep_busy_i,
  input  logic [N_EP*SRC_W-1:0] ep_owner_i,
  input  logic [N_INI*DW-1:0]   ini_wdata_i,
  input  logic [N_EP*DW-1:0]    ep_rdata_i,
  output logic [N_INI-1:0]      ini_gnt_o,
  output logic [N_INI*DW-1:0]   ini_rdata_o,
  output logic [N_EP*DW-1:0]    ep_wdata_o
);
  always_comb begin
    ini_gnt_o   = '0;
    ini_rdata_o = '0;
    ep_wdata_o  = '0;
    for (int e = 0; e < N_EP; e++) begin
      for (int i = 0; i < N_INI; i++) begin
        if (ep_busy_i[e] && ep_owner_i[e*SRC_W +: SRC_W] == SRC_W'(i)) begin
          ini_gnt_o[i]               = 1'b1;
          ini_rdata_o[i*DW +: DW]    = ini_rdata_o[i*DW +: DW] | ep_rdata_i[e*DW +: DW];
          ep_wdata_o[e*DW +: DW]     = ini_wdata_i[i*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/rt_xbar.sv
module rt_xbar
  import rt_xbar_pkg::*;
#(
  parameter int DW       = 32,
  parameter int LEN_W    = 8,
  parameter int N_EP     = 4,
  parameter int DMEM1_EP = 1,
  localparam int EP_W    = $clog2(N_EP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_INI-1:0]       ini_req,
  input  logic [N_INI*EP_W-1:0]  ini_ep,
  input  logic [N_INI-1:0]       ini_wr,
  input  logic [N_INI*LEN_W-1:0] ini_len,
  input  logic [N_INI*DW-1:0]    ini_wdata,
  output logic [N_INI-1:0]       ini_gnt,
  output logic [N_INI*DW-1:0]    ini_rdata,
  output logic [N_EP-1:0]        ep_vld,
  output logic [N_EP-1:0]        ep_last,
  output logic [N_EP-1:0]        ep_wr,
  output logic [N_EP*SRC_W-1:0]  ep_src,
  output logic [N_EP*DW-1:0]     ep_wdata,
  input  logic [N_EP*DW-1:0]     ep_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_EP-1:0]       ep_busy;
  logic [N_EP*SRC_W-1:0] ep_owner;

  for (genvar e = 0; e < N_EP; e++) begin : g_ep
    logic [N_INI-1:0] cand;
    always_comb begin
      for (int i = 0; i < N_INI; i++) begin
        cand[i] = ini_req[i] && (ini_ep[i*EP_W +: EP_W] == EP_W'(e));
      end
    end
    rt_xbar_ep_arb #(
      .LEN_W (LEN_W),
      .FAV   ((e == DMEM1_EP) ? CORE1 : CORE0)
    ) u_arb (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .cand_i  (cand),
      .len_i   (ini_len),
      .wr_i    (ini_wr),
      .busy_o  (ep_busy[e]),
      .last_o  (ep_last[e]),
      .owner_o (ep_owner[e*SRC_W +: SRC_W]),
      .wr_o    (ep_wr[e])
    );
  end

  rt_xbar_route #(.DW(DW), .N_EP(N_EP)) u_route (
    .ep_busy_i   (ep_busy),
    .ep_owner_i  (ep_owner),
    .ini_wdata_i (ini_wdata),
    .ep_rdata_i  (ep_rdata),
    .ini_gnt_o   (ini_gnt),
    .ini_rdata_o (ini_rdata),
    .ep_wdata_o  (ep_wdata)
  );

  assign ep_vld = ep_busy;
  assign ep_src = ep_owner;

  // R1: an initiator owns at most one endpoint at a time
  for (genvar i = 0; i < N_INI; i++) begin : g_own_chk
    logic [N_EP-1:0] own_vec;
    always_comb begin
      for (int e = 0; e < N_EP; e++) begin
        own_vec[e] = ep_busy[e] && (ep_owner[e*SRC_W +: SRC_W] == SRC_W'(i));
      end
    end
    a_r1_single_owner: assert property (@(posedge clk) disable iff (!rst_int_n)
      $countones(own_vec) <= 1);
  end

  // R9: nothing is granted while the internal reset is held
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |=> ep_busy == '0);
endmodule

// File: tb/rt_xbar_tb_top.sv
module rt_xbar_tb_top;
  localparam int NI = 3;
  localparam int NE = 4;

  logic          clk;
  logic          rst_n;
  logic [NI-1:0] ini_req;
  logic [NI*2-1:0] ini_ep;
  logic [NI-1:0] ini_wr;
  logic [NI*8-1:0] ini_len;
  logic [NI*32-1:0] ini_wdata;
  logic [NI-1:0] ini_gnt;
  logic [NI*32-1:0] ini_rdata;
  logic [NE-1:0] ep_vld, ep_last, ep_wr;
  logic [NE*2-1:0] ep_src;
  logic [NE*32-1:0] ep_wdata;
  logic [NE*32-1:0] ep_rdata;

  rt_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .ini_req(ini_req), .ini_ep(ini_ep), .ini_wr(ini_wr),
    .ini_len(ini_len), .ini_wdata(ini_wdata), .ini_gnt(ini_gnt), .ini_rdata(ini_rdata),
    .ep_vld(ep_vld), .ep_last(ep_last), .ep_wr(ep_wr), .ep_src(ep_src),
    .ep_wdata(ep_wdata), .ep_rdata(ep_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int ep;
    int beats;
    int start;
    bit wr;
    logic [31:0] wd;
    string tag;
  } exp_t;

  exp_t q0[$], q1[$], q2[$];
  exp_t cur[NI];
  int rise_cyc[NI];
  logic [NI-1:0] gnt_prev = '0;

  for (genvar e = 0; e < NE; e++) begin : g_rd
    assign ep_rdata[e*32 +: 32] = 32'hD00D_0000 + e;
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void push(int i, exp_t it);
    case (i)
      0: q0.push_back(it);
      1: q1.push_back(it);
      default: q2.push_back(it);
    endcase
  endfunction

  function automatic bit pop(int i, output exp_t it);
    case (i)
      0: begin if (q0.size() == 0) return 0; it = q0.pop_front(); end
      1: begin if (q1.size() == 0) return 0; it = q1.pop_front(); end
      default: begin if (q2.size() == 0) return 0; it = q2.pop_front(); end
    endcase
    return 1;
  endfunction

  // monitor: grant start cycle, routing on first beat, duration at end
  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < NI; i++) begin
        if (ini_gnt[i] && !gnt_prev[i]) begin
          exp_t it;
          if (!pop(i, it)) begin
            tests++; fails++;
            $display("FAIL R7 unexpected grant on initiator %0d: actual 1 expected 0", i);
            it = '{ep: 0, beats: 0, start: cyc, wr: 0, wd: 0, tag: "R7"};
          end else begin
            chk(it.tag, "grant start cycle", cyc, it.start);
            chk("R8", "endpoint valid", ep_vld[it.ep], 1);
            chk("R8", "endpoint source", ep_src[it.ep*2 +: 2], i);
            chk("R8", "endpoint write flag", ep_wr[it.ep], it.wr);
            chk("R8", "endpoint write data", ep_wdata[it.ep*32 +: 32], it.wd);
            chk("R8", "returned read data", ini_rdata[i*32 +: 32], 32'hD00D_0000 + it.ep);
          end
          cur[i] = it;
          rise_cyc[i] = cyc;
        end else if (!ini_gnt[i] && gnt_prev[i] && cur[i].beats != 0) begin
          chk("R2", "grant length", cyc - rise_cyc[i], cur[i].beats);
        end
      end
      gnt_prev = ini_gnt;
    end
  end

  // driver: call at a negedge; start is the absolute cycle the grant is expected
  task automatic drive(int i, int e, int len, bit wr, int start, string tag);
    exp_t it;
    logic [31:0] wd;
    wd = 32'hC0DE_0000 | (i << 8) | len;
    it = '{ep: e, beats: (len == 0) ? 1 : (len + 3) / 4, start: start, wr: wr, wd: wd, tag: tag};
    push(i, it);
    ini_ep[i*2 +: 2]     = e[1:0];
    ini_len[i*8 +: 8]    = len[7:0];
    ini_wr[i]            = wr;
    ini_wdata[i*32 +: 32] = wd;
    ini_req[i]           = 1'b1;
    do @(negedge clk); while (!ini_gnt[i]);
    ini_req[i] = 1'b0;
    do @(negedge clk); while (ini_gnt[i]);
  endtask

  task automatic gap();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b;
    ini_req = '0; ini_ep = '0; ini_wr = '0; ini_len = '0; ini_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", "grants in reset", ini_gnt, 0);
    chk("R9", "valids in reset", ep_vld, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9", "grants after reset", ini_gnt, 0);
    chk("R9", "valids after reset", ep_vld, 0);

    // R1: three initiators, three different endpoints
    b = cyc;
    fork
      drive(0, 0, 4, 1, b + 1, "R1");
      drive(1, 1, 8, 0, b + 1, "R1");
      drive(2, 2, 12, 1, b + 1, "R1");
    join
    gap();

    // R3 / R7: core 0 and host on the peripheral
    b = cyc;
    fork
      drive(0, 3, 8, 0, b + 1, "R3");
      drive(2, 3, 8, 1, b + 3, "R7");
    join
    gap();

    // R4: cores collide on core 1's memory
    b = cyc;
    fork
      drive(0, 1, 4, 0, b + 2, "R4");
      drive(1, 1, 4, 1, b + 1, "R4");
    join
    gap();

    // R4: cores collide on shared memory
    b = cyc;
    fork
      drive(0, 2, 4, 1, b + 1, "R4");
      drive(1, 2, 4, 0, b + 2, "R4");
    join
    gap();

    // R4: cores collide on core 0's memory
    b = cyc;
    fork
      drive(0, 0, 4, 0, b + 1, "R4");
      drive(1, 0, 8, 1, b + 2, "R4");
    join
    gap();

    // R2: length corners
    b = cyc;
    drive(2, 2, 30, 1, b + 1, "R2");
    gap();
    b = cyc;
    drive(1, 3, 0, 0, b + 1, "R2");
    gap();
    b = cyc;
    drive(0, 2, 5, 1, b + 1, "R2");
    gap();

    // R5: late cores during an 8-beat host burst
    b = cyc;
    fork
      drive(2, 0, 30, 1, b + 1, "R5");
      begin @(negedge clk); drive(0, 0, 4, 0, b + 9, "R5"); end
      begin repeat (4) @(negedge clk); drive(1, 0, 4, 1, b + 10, "R5"); end
    join
    gap();

    // R6: host single-word accesses, core cuts in at the next point
    b = cyc;
    fork
      begin
        drive(2, 3, 4, 1, b + 1, "R6");
        drive(2, 3, 4, 1, b + 3, "R6");
      end
      begin @(negedge clk); drive(1, 3, 4, 0, b + 2, "R6"); end
    join
    gap();

    // R1 / R3: mixed disjoint and conflicting traffic
    b = cyc;
    fork
      drive(0, 2, 16, 0, b + 1, "R1");
      drive(1, 3, 4, 1, b + 1, "R1");
      drive(2, 2, 4, 0, b + 5, "R3");
    join
    gap();

    chk("R7", "pending expectations left", q0.size() + q1.size() + q2.size(), 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule